// File: doc/BRIEF.md
# Floating-Point Control and Status Register Unit

This block keeps the 32-bit control and status word of a floating-point unit and gives software four ways to reach it through a 5-bit register number: the whole word, a condensed condition-code view, an exceptions view (cause and sticky flags) and an enables view (rounding, enables, flush-to-zero). Reads are combinational. Writes land on the next clock edge. Each partial view moves its bits to and from fixed places in the word and refuses a write whose guard bits are set. Whole-word writes go through a writable-bit mask that is chosen when the unit is instantiated.

The field layout inside the word is: rounding mode [1:0], sticky flags [6:2], enables [11:7], cause [17:12] with [17] the unimplemented-operation cause, NaN-2008 [18], ABS-2008 [19], condition code 0 [23], flush-to-zero [24], condition codes 7..1 [31:25]. The unit drives the rounding mode, flush-to-zero and signalling-NaN polarity straight from the word. A side port lets the arithmetic datapath set or clear a single condition code.

A small two-state machine produces the exception request. State `EXC_IDLE` moves to `EXC_CHECK` on an accepted write (transition *write_taken*). `EXC_CHECK` stays in `EXC_CHECK` when another write is accepted (*write_again*) and otherwise goes back to `EXC_IDLE` (*settle*). While in `EXC_CHECK`, the request is high if any pending cause is enabled. The unimplemented cause counts as always enabled.

Top module: `fpctl_reg_unit`

## Requirements
- R1: After reset the word is 0x00000000. When parameter RESET_2008 is 1, it is instead 0x000C0000, with bits 18 and 19 set.
- R2: A read of register 25 returns word[31:25] in result[7:1] and word[23] in result[0]. All other result bits are zero.
- R3: A write to register 25 is refused when any of data[31:8] is set or when rel6_mode is high. Otherwise data[7:1] goes to word[31:25] and data[0] goes to word[23], and every other bit is kept.
- R4: A read of register 26 returns word & 0x0003F07C. A write to 26 is refused when any of data[22:18] is set. Otherwise only the bits under 0x0003F07C are replaced from data.
- R5: A read of register 28 returns (word & 0x00000F83) with word[24] placed in result[2]. A write to 28 is refused when any of data[22:18] is set. Otherwise the bits under 0x00000F83 are replaced from data and word[24] takes data[2].
- R6: A write to register 31 yields (data & M) | (old & ~M). M is 0xFF83FFFF by default, and 0x0183FFFF when LEGACY_CC is 1.
- R7: A write to any other register number leaves the word unchanged. A read of any other number returns the whole word.
- R8: fp_exc_req is high for exactly the cycle after an accepted write, and only when (word[17:12] & {1, word[11:7]}) is nonzero for the new word. A refused or ignored write never raises it.
- R9: round_mode equals word[1:0], flush_zero equals word[24], and snan_is_one is the inverse of word[18].
- R10: cc_wr with cc_idx=n writes cc_val into condition code n (bit 23 for n=0, bit 24+n otherwise) at the next edge. If a register write is accepted in the same cycle, the condition-code update is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rel6_mode | input | 1 | Refuses condition-code view writes when high |
| reg_sel | input | 5 | Register number for read and write |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Combinational read result for reg_sel |
| cc_wr | input | 1 | Condition-code update strobe |
| cc_idx | input | 3 | Condition code to update |
| cc_val | input | 1 | New condition-code value |
| round_mode | output | 2 | Current rounding mode |
| flush_zero | output | 1 | Flush-to-zero control |
| snan_is_one | output | 1 | High when a set quiet bit marks a signalling NaN |
| fp_exc_req | output | 1 | One-cycle floating-point exception request |

## Verification
A wrong bit in the word reaches rd_data as soon as the matching view is selected, in the same cycle, and it reaches the control outputs directly. This is why every read also checks round_mode, flush_zero and snan_is_one. A wrong exception state machine shows up as a missing, extra or stretched fp_exc_req pulse. The bench checks the cycle after each write for the pulse and the cycle after that for its absence. Refused writes are confirmed through a later whole-word read.

// File: rtl/fpctl_pkg.sv
package fpctl_pkg;
    localparam int WORD_W   = 32;
    localparam int SEL_W    = 5;
    localparam int NUM_CC   = 8;
    localparam int CC_IDX_W = $clog2(NUM_CC);

    localparam logic [SEL_W-1:0] SEL_CC   = 5'd25;
    localparam logic [SEL_W-1:0] SEL_EXC  = 5'd26;
    localparam logic [SEL_W-1:0] SEL_ENA  = 5'd28;
    localparam logic [SEL_W-1:0] SEL_FULL = 5'd31;

    localparam int POS_NAN  = 18;
    localparam int POS_ABS  = 19;
    localparam int POS_CC0  = 23;
    localparam int POS_FZ   = 24;
    localparam int POS_CCHI = 25;

    localparam logic [WORD_W-1:0] FLD_RM    = 32'h0000_0003;
    localparam logic [WORD_W-1:0] FLD_FLAG  = 32'h0000_007C;
    localparam logic [WORD_W-1:0] FLD_ENA   = 32'h0000_0F80;
    localparam logic [WORD_W-1:0] FLD_CAUSE = 32'h0003_F000;
    localparam logic [WORD_W-1:0] FLD_CCHI  = 32'hFE00_0000;
    localparam logic [WORD_W-1:0] FLD_GUARD = 32'h007C_0000;
    localparam logic [WORD_W-1:0] FLD_CC0   = 32'h1 << POS_CC0;
    localparam logic [WORD_W-1:0] FLD_FZ    = 32'h1 << POS_FZ;

    typedef enum logic {
        EXC_IDLE,
        EXC_CHECK
    } exc_state_e;
endpackage

// File: rtl/fpctl_view_read.sv
module fpctl_view_read
    import fpctl_pkg::*;
(
    input  logic [WORD_W-1:0] cur,
    input  logic [SEL_W-1:0]  sel,
    output logic [WORD_W-1:0] rd_data
);
    always_comb begin
        unique case (sel)
            SEL_CC:  rd_data = {24'd0, cur[WORD_W-1:POS_CCHI], cur[POS_CC0]};
            SEL_EXC: rd_data = cur & (FLD_CAUSE | FLD_FLAG);
            SEL_ENA: rd_data = (cur & (FLD_RM | FLD_ENA)) | {29'd0, cur[POS_FZ], 2'd0};
            default: rd_data = cur;
        endcase
    end
endmodule

// File: rtl/fpctl_write_merge.sv
module fpctl_write_merge
    import fpctl_pkg::*;
#(
    parameter logic [WORD_W-1:0] WR_MASK = 32'hFF83_FFFF
) (
    input  logic [WORD_W-1:0] cur,
    input  logic [SEL_W-1:0]  sel,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              rel6_mode,
    output logic [WORD_W-1:0] nxt,
    output logic              accept
);
    localparam logic [WORD_W-1:0] EXC_FIELDS = FLD_CAUSE | FLD_FLAG;
    localparam logic [WORD_W-1:0] ENA_DATA   = FLD_RM | FLD_ENA;

    logic guard_hit;
    logic cc_hi_hit;

    assign guard_hit = |(wr_data & FLD_GUARD);
    assign cc_hi_hit = |wr_data[WORD_W-1:8];

    always_comb begin
        nxt    = cur;
        accept = 1'b0;
        if (wr_en) begin
            unique case (sel)
                SEL_CC: begin
                    if (!cc_hi_hit && !rel6_mode) begin
                        accept = 1'b1;
                        nxt    = {wr_data[7:1], cur[POS_FZ], wr_data[0], cur[POS_CC0-1:0]};
                    end
                end
                SEL_EXC: begin
                    if (!guard_hit) begin
                        accept = 1'b1;
                        nxt    = (cur & ~EXC_FIELDS) | (wr_data & EXC_FIELDS);
                    end
                end
                SEL_ENA: begin
                    if (!guard_hit) begin
                        accept = 1'b1;
                        nxt    = (cur & ~(ENA_DATA | FLD_FZ)) | (wr_data & ENA_DATA);
                        nxt[POS_FZ] = wr_data[2];
                    end
                end
                SEL_FULL: begin
                    accept = 1'b1;
                    nxt    = (wr_data & WR_MASK) | (cur & ~WR_MASK);
                end
                default: begin
                    accept = 1'b0;
                    nxt    = cur;
                end
            endcase
        end
    end
endmodule

// File: rtl/fpctl_exc_fsm.sv
module fpctl_exc_fsm
    import fpctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [WORD_W-1:0] cur,
    output logic              fp_exc_req
);
    exc_state_e state_q, state_d;
    logic       pending_hit;

    assign pending_hit = |(cur[17:12] & {1'b1, cur[11:7]});

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            EXC_IDLE:  if (accept) state_d = EXC_CHECK;
            EXC_CHECK: state_d = accept ? EXC_CHECK : EXC_IDLE;
            default:   state_d = EXC_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= EXC_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            EXC_CHECK: fp_exc_req = pending_hit;
            default:   fp_exc_req = 1'b0;
        endcase
    end

    assert_exc_after_wr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fp_exc_req |-> $past(accept));

    assert_exc_idle_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == EXC_IDLE) |-> !fp_exc_req);
endmodule

// File: rtl/fpctl_reg_unit.sv
module fpctl_reg_unit
    import fpctl_pkg::*;
#(
    parameter bit LEGACY_CC  = 1'b0,
    parameter bit RESET_2008 = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rel6_mode,
    input  logic [SEL_W-1:0]  reg_sel,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] rd_data,
    input  logic              cc_wr,
    input  logic [CC_IDX_W-1:0] cc_idx,
    input  logic              cc_val,
    output logic [1:0]        round_mode,
    output logic              flush_zero,
    output logic              snan_is_one,
    output logic              fp_exc_req
);
    localparam logic [WORD_W-1:0] BASE_MASK = FLD_RM | FLD_FLAG | FLD_ENA | FLD_CAUSE | FLD_FZ | FLD_CC0;
    localparam logic [WORD_W-1:0] WR_MASK   = LEGACY_CC ? BASE_MASK : (BASE_MASK | FLD_CCHI);
    localparam logic [WORD_W-1:0] RST_VAL   = RESET_2008 ? ((32'h1 << POS_NAN) | (32'h1 << POS_ABS)) : '0;

    logic [WORD_W-1:0] word_q, word_d, merge_nxt;
    logic              wr_accept;
    logic [WORD_W-1:0] cc_onehot;
    logic [SEL_W-1:0]  cc_bitpos;

    fpctl_view_read u_read (
        .cur     (word_q),
        .sel     (reg_sel),
        .rd_data (rd_data)
    );

    fpctl_write_merge #(.WR_MASK(WR_MASK)) u_merge (
        .cur       (word_q),
        .sel       (reg_sel),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .rel6_mode (rel6_mode),
        .nxt       (merge_nxt),
        .accept    (wr_accept)
    );

    fpctl_exc_fsm u_exc (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (wr_accept),
        .cur        (word_q),
        .fp_exc_req (fp_exc_req)
    );

    generate
        for (genvar g = 0; g < NUM_CC; g++) begin : g_cc_map
            localparam int BITP = (g == 0) ? POS_CC0 : (POS_FZ + g);
            assign cc_onehot[BITP] = cc_wr && (cc_idx == CC_IDX_W'(g));
        end
        for (genvar b = 0; b < WORD_W; b++) begin : g_cc_zero
            if (!(b == POS_CC0 || b >= POS_CCHI)) begin : g_z
                assign cc_onehot[b] = 1'b0;
            end
        end
    endgenerate

    assign cc_bitpos = (cc_idx == '0) ? SEL_W'(POS_CC0) : SEL_W'(POS_FZ) + SEL_W'(cc_idx);

    always_comb begin
        word_d = word_q;
        if (wr_accept)
            word_d = merge_nxt;
        else
            word_d = (word_q & ~cc_onehot) | (cc_val ? cc_onehot : '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) word_q <= RST_VAL;
        else        word_q <= word_d;
    end

    assign round_mode  = word_q[1:0];
    assign flush_zero  = word_q[POS_FZ];
    assign snan_is_one = ~word_q[POS_NAN];

    assert_cc_reject_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_sel == SEL_CC && (rel6_mode || |wr_data[31:8]) && !cc_wr) |=> $stable(word_q));

    assert_full_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_sel == SEL_FULL) |=> ((word_q & ~WR_MASK) == ($past(word_q) & ~WR_MASK)));

    assert_other_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !cc_wr && reg_sel != SEL_CC && reg_sel != SEL_EXC &&
         reg_sel != SEL_ENA && reg_sel != SEL_FULL) |=> $stable(word_q));

    assert_cc_update_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cc_wr && !wr_accept) |=> (word_q[$past(cc_bitpos)] == $past(cc_val)));
endmodule

// File: tb/fpctl_reg_unit_tb_top.sv
module fpctl_reg_unit_tb_top;
    localparam logic [31:0] M_FULL  = 32'hFF83_FFFF;
    localparam logic [31:0] M_RST   = 32'h000C_0000;
    localparam int K_RD = 0, K_EXC = 1, K_OUT = 2;

    typedef struct {
        int          due;
        int          kind;
        logic [31:0] exp;
        string       tag;
    } sb_item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rel6_mode = 1'b0;
    logic [4:0]  reg_sel = 5'd31;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        cc_wr = 1'b0;
    logic [2:0]  cc_idx = '0;
    logic        cc_val = 1'b0;
    logic [1:0]  round_mode;
    logic        flush_zero, snan_is_one, fp_exc_req;

    int n_chk = 0, n_bad = 0, cyc = 0;
    logic [31:0] mreg;
    sb_item_t sb_q[$];
    sb_item_t mon_it;
    logic [31:0] mon_act;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    fpctl_reg_unit dut_i (
        .clk(clk), .rst_n(rst_n), .rel6_mode(rel6_mode), .reg_sel(reg_sel),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .cc_wr(cc_wr),
        .cc_idx(cc_idx), .cc_val(cc_val), .round_mode(round_mode),
        .flush_zero(flush_zero), .snan_is_one(snan_is_one), .fp_exc_req(fp_exc_req)
    );

    function automatic logic [31:0] m_view(logic [31:0] r, logic [4:0] s);
        case (s)
            5'd25:   return {24'd0, r[31:25], r[23]};
            5'd26:   return r & 32'h0003_F07C;
            5'd28:   return (r & 32'h0000_0F83) | {29'd0, r[24], 2'd0};
            default: return r;
        endcase
    endfunction

    function automatic logic [32:0] m_write(logic [31:0] r, logic [4:0] s, logic [31:0] d, logic r6);
        logic [31:0] n;
        n = r;
        case (s)
            5'd25: begin
                if (r6 || (d[31:8] != 0)) return {1'b0, r};
                n[31:25] = d[7:1];
                n[23]    = d[0];
                return {1'b1, n};
            end
            5'd26: begin
                if (d[22:18] != 0) return {1'b0, r};
                return {1'b1, (r & ~32'h0003_F07C) | (d & 32'h0003_F07C)};
            end
            5'd28: begin
                if (d[22:18] != 0) return {1'b0, r};
                n = (r & ~32'h0100_0F83) | (d & 32'h0000_0F83);
                n[24] = d[2];
                return {1'b1, n};
            end
            5'd31:   return {1'b1, (d & M_FULL) | (r & ~M_FULL)};
            default: return {1'b0, r};
        endcase
    endfunction

    function automatic logic m_hit(logic [31:0] r);
        return |(r[17:12] & {1'b1, r[11:7]});
    endfunction

    task automatic push(int due, int kind, logic [31:0] exp, string tag);
        sb_item_t it;
        it.due = due; it.kind = kind; it.exp = exp; it.tag = tag;
        sb_q.push_back(it);
    endtask

    // general driver: optional register write plus optional condition-code update
    task automatic drive(logic we, logic [4:0] s, logic [31:0] d, logic r6,
                         logic cw, logic [2:0] ci, logic cv, string tag);
        logic [32:0] res;
        @(negedge clk);
        wr_en = we; reg_sel = s; wr_data = d; rel6_mode = r6;
        cc_wr = cw; cc_idx = ci; cc_val = cv;
        res = we ? m_write(mreg, s, d, r6) : {1'b0, mreg};
        if (res[32]) mreg = res[31:0];
        else if (cw) begin
            if (ci == 0) mreg[23] = cv;
            else         mreg[24 + ci] = cv;
        end
        push(cyc + 1, K_EXC, {31'd0, res[32] && m_hit(mreg)}, {tag, "/R8"});
        @(negedge clk);
        wr_en = 1'b0; cc_wr = 1'b0; rel6_mode = 1'b0;
        push(cyc + 1, K_EXC, 32'd0, {tag, "/R8-once"});
    endtask

    task automatic wr(logic [4:0] s, logic [31:0] d, string tag);
        drive(1'b1, s, d, 1'b0, 1'b0, 3'd0, 1'b0, tag);
    endtask

    task automatic rd(logic [4:0] s, string tag);
        @(negedge clk);
        reg_sel = s;
        push(cyc + 1, K_RD, m_view(mreg, s), tag);
        push(cyc + 1, K_OUT, {28'd0, mreg[1:0], mreg[24], ~mreg[18]}, {tag, "/R9"});
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // monitor: pop every expectation due this cycle and compare
    always @(posedge clk) begin
        #2;
        while (sb_q.size() > 0 && sb_q[0].due <= cyc) begin
            mon_it = sb_q.pop_front();
            case (mon_it.kind)
                K_RD:    mon_act = rd_data;
                K_EXC:   mon_act = {31'd0, fp_exc_req};
                default: mon_act = {28'd0, round_mode, flush_zero, snan_is_one};
            endcase
            n_chk++;
            if (mon_it.due != cyc || mon_act !== mon_it.exp) begin
                n_bad++;
                $display("FAIL %s: actual=%h expected=%h (cycle %0d due %0d)",
                         mon_it.tag, mon_act, mon_it.exp, cyc, mon_it.due);
            end
        end
    end

    initial begin
        #2_000_000;
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        mreg = M_RST;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        rd(5'd31, "R1 reset value");
        rd(5'd25, "R2 reset cc view");
        // enables view
        wr(5'd28, 32'h0000_0F87, "R5 enables write");
        rd(5'd28, "R5 enables read");
        rd(5'd31, "R5 full after enables");
        wr(5'd28, 32'h0010_0001, "R5 guarded write refused");
        rd(5'd31, "R5 refused leaves word");
        // exceptions view
        wr(5'd26, 32'h0003_F07C, "R4 exceptions write");
        rd(5'd26, "R4 exceptions read");
        wr(5'd26, 32'h0004_0000, "R4 guarded write refused");
        rd(5'd31, "R4 refused leaves word");
        // condition-code view
        wr(5'd25, 32'h0000_00A5, "R3 cc write");
        rd(5'd25, "R2 cc read");
        rd(5'd31, "R3 full after cc write");
        wr(5'd25, 32'h0000_0100, "R3 high data refused");
        drive(1'b1, 5'd25, 32'h0000_0001, 1'b1, 1'b0, 3'd0, 1'b0, "R3 rel6 refused");
        rd(5'd31, "R3 refused leaves word");
        // full view with mask
        wr(5'd31, 32'h0000_0000, "R6 full clear");
        rd(5'd31, "R6 locked bits kept");
        wr(5'd31, 32'hFFFF_FFFF, "R6 full set");
        rd(5'd31, "R6 mask applied");
        wr(5'd31, 32'h0002_0000, "R8 unimplemented always enabled");
        wr(5'd31, 32'h0000_1000, "R8 cause without enable");
        wr(5'd31, 32'h0000_1080, "R8 cause with enable");
        wr(5'd31, 32'h0000_0002, "R9 rounding mode");
        rd(5'd31, "R9 outputs follow word");
        // other numbers
        wr(5'd7, 32'hFFFF_FFFF, "R7 other write ignored");
        rd(5'd7, "R7 other read full");
        rd(5'd0, "R7 read zero number");
        // condition-code side port
        drive(1'b0, 5'd31, 32'h0, 1'b0, 1'b1, 3'd3, 1'b1, "R10 set cc3");
        drive(1'b0, 5'd31, 32'h0, 1'b0, 1'b1, 3'd0, 1'b1, "R10 set cc0");
        rd(5'd25, "R10 cc view after sets");
        drive(1'b0, 5'd31, 32'h0, 1'b0, 1'b1, 3'd3, 1'b0, "R10 clear cc3");
        rd(5'd31, "R10 full after clear");
        drive(1'b1, 5'd31, 32'h0000_0000, 1'b0, 1'b1, 3'd7, 1'b1, "R10 write wins");
        rd(5'd31, "R10 cc update dropped");
        drive(1'b1, 5'd9, 32'h0000_0000, 1'b0, 1'b1, 3'd7, 1'b1, "R10 ignored write keeps cc");
        rd(5'd25, "R10 cc7 set");
        repeat (4) @(negedge clk);
        if (sb_q.size() != 0) begin
            n_bad++;
            $display("FAIL scoreboard: actual=%0d expected=0 items left", sb_q.size());
        end
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule